// File: doc/BRIEF.md
# Sectored Write-Through Data Cache

This block is a four-way set-associative data cache that sits between a word-wide load/store port and a simple memory port. It holds 64-byte lines, 8 KB in total (32 sets by default), and picks victims with a three-bit tree pseudo-LRU per set. Stores never leave dirty data behind. Each one goes straight to memory as a single line-wide transaction with byte strobes, and it also refreshes the cached copy when the line is present.

A read miss fetches a sector: first the missing line, then its neighbour. The neighbour is the line whose address differs only in bit 6, so it lands in the adjacent set. The core gets its word as soon as the first line has arrived. The neighbour is fetched only if it is not already cached. The core side handles one request at a time. It drops `req_ready` while a lookup, a fill or a write-through is in progress.

Top module: `sect_wt_cache`

## Requirements
- R1: After reset every line is invalid, `req_ready` is 1, and `resp_valid`, `mem_rd_valid` and `mem_wr_valid` are 0. The first read of any address misses.
- R2: A read that hits raises `resp_valid` for one cycle, two clock edges after the edge that accepted the request, with the cached word on `resp_rdata`.
- R3: A read that misses issues a burst read of the requested line. Its 16 words arrive in order on `mem_rdata` while `mem_rdata_valid` is 1. The core response, with the requested word, follows the last beat of that line.
- R4: After the requested line is filled, a second burst read is issued for the neighbour line (line address XOR 1). Once that fill completes, later reads of the neighbour hit.
- R5: If the neighbour line is already cached, no second burst is issued. The miss then costs exactly one burst read.
- R6: Every accepted store produces exactly one memory write. `mem_wr_line` is the line address and the word is replicated across `mem_wr_data`. Exactly four strobe bits are set: bits 4*w to 4*w+3 of `mem_wr_strb`, where w is address bits [5:2].
- R7: A store that hits updates the cached word, so a later read hits and returns the new value. A store that misses allocates nothing, so a later read of that line misses.
- R8: `req_ready` is 0 from the cycle after acceptance until the request, including any neighbour fill, has completed. The read request holds its line address until it is granted.
- R9: A fill takes the lowest-numbered invalid way first. When all ways are valid, the fill takes the tree pseudo-LRU victim. Every hit and every fill points the tree away from the way it used. At most one way of a set matches a given line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Cache can accept a request |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | AW | Byte address, word aligned |
| req_wdata | input | 32 | Store data |
| resp_valid | output | 1 | Load data valid (one-cycle pulse) |
| resp_rdata | output | 32 | Load data |
| mem_rd_valid | output | 1 | Burst read request |
| mem_rd_ready | input | 1 | Burst read request accepted |
| mem_rd_line | output | AW-6 | Line address of the burst read |
| mem_rdata_valid | input | 1 | Burst data beat valid |
| mem_rdata | input | 32 | Burst data beat, word 0 first |
| mem_wr_valid | output | 1 | Line-wide write request |
| mem_wr_ready | input | 1 | Write accepted |
| mem_wr_line | output | AW-6 | Line address of the write |
| mem_wr_data | output | 32*LINE_WORDS | Write data, store word in every lane |
| mem_wr_strb | output | 4*LINE_WORDS | Byte strobes, one lane of four set |

## Verification
Two pairs of actions share a cycle here. The first is the cycle that completes the primary fill: it writes the tag, advances the replacement tree, delivers the core's word and starts the neighbour check, all at once. The bench provokes this with misses whose neighbour lands in a set whose state it has steered. It judges the outcome by the data the scoreboard receives and by how many burst reads follow. The second is a store that hits: the lookup updates the cached word in the same cycle that the write-through is launched. An immediate reread must return the new word as a hit, and the memory must see exactly one strobed write.

// File: rtl/sect_wt_cache.sv
module sect_wt_cache #(
  parameter int AW = 32,
  parameter int SETS = 32,
  parameter int LINE_WORDS = 16,
  localparam int OB = $clog2(LINE_WORDS),
  localparam int LB = OB + 2,
  localparam int LW = AW - LB,
  localparam int SB = $clog2(SETS),
  localparam int TW = LW - SB
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_we,
  input  logic [AW-1:0]           req_addr,
  input  logic [31:0]             req_wdata,
  output logic                    resp_valid,
  output logic [31:0]             resp_rdata,
  output logic                    mem_rd_valid,
  input  logic                    mem_rd_ready,
  output logic [LW-1:0]           mem_rd_line,
  input  logic                    mem_rdata_valid,
  input  logic [31:0]             mem_rdata,
  output logic                    mem_wr_valid,
  input  logic                    mem_wr_ready,
  output logic [LW-1:0]           mem_wr_line,
  output logic [32*LINE_WORDS-1:0] mem_wr_data,
  output logic [4*LINE_WORDS-1:0]  mem_wr_strb
);
  typedef enum logic [2:0] {IDLE, LOOK, HIT, WR, RDREQ, RDBEAT, PCHK} st_t;
  st_t st;

  logic [LW-1:0] line_q;
  logic [OB-1:0] word_q, cnt_q;
  logic          we_q, second_q;
  logic [31:0]   wd_q;
  logic [1:0]    hway_q, fway_q;

  logic [TW-1:0] tags [SETS][4];
  logic [3:0]    vld  [SETS];
  logic [2:0]    plru [SETS];
  logic [31:0]   dat  [SETS*4*LINE_WORDS];

  logic [SB-1:0] set_w;
  logic [TW-1:0] tag_w;
  logic [3:0]    hitv;
  logic          hit;
  logic [1:0]    hway, vict;
  logic          unused_bits;

  assign set_w = line_q[SB-1:0];
  assign tag_w = line_q[LW-1:SB];
  assign unused_bits = ^req_addr[1:0];

  always_comb begin
    for (int i = 0; i < 4; i++) hitv[i] = vld[set_w][i] && (tags[set_w][i] == tag_w);
    hway = 2'd0;
    for (int i = 0; i < 4; i++) if (hitv[i]) hway = 2'(i);
    vict = plru[set_w][0] ? {1'b1, plru[set_w][2]} : {1'b0, plru[set_w][1]};
    for (int i = 3; i >= 0; i--) if (!vld[set_w][i]) vict = 2'(i);
  end
  assign hit = |hitv;

  function automatic logic [2:0] plru_next(input logic [2:0] p, input logic [1:0] w);
    logic [2:0] n;
    n = p;
    n[0] = ~w[1];
    if (w[1]) n[2] = ~w[0];
    else      n[1] = ~w[0];
    return n;
  endfunction

  assign req_ready    = (st == IDLE);
  assign mem_rd_valid = (st == RDREQ);
  assign mem_rd_line  = line_q;
  assign mem_wr_valid = (st == WR);
  assign mem_wr_line  = line_q;
  assign mem_wr_data  = {LINE_WORDS{wd_q}};
  assign mem_wr_strb  = {{(4*LINE_WORDS-4){1'b0}}, 4'hF} << {word_q, 2'b00};

  wire last_beat = (st == RDBEAT) && mem_rdata_valid && (cnt_q == OB'(LINE_WORDS-1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE;
      resp_valid <= 1'b0;
      for (int s = 0; s < SETS; s++) begin
        vld[s] <= '0;
        plru[s] <= '0;
      end
    end else begin
      resp_valid <= 1'b0;
      case (st)
        IDLE: if (req_valid) begin
          line_q <= req_addr[AW-1:LB];
          word_q <= req_addr[LB-1:2];
          we_q <= req_we;
          wd_q <= req_wdata;
          second_q <= 1'b0;
          st <= LOOK;
        end
        LOOK: begin
          if (hit) plru[set_w] <= plru_next(plru[set_w], hway);
          if (we_q) st <= WR;
          else if (hit) begin hway_q <= hway; st <= HIT; end
          else begin fway_q <= vict; st <= RDREQ; end
        end
        HIT: begin resp_valid <= 1'b1; st <= IDLE; end
        WR: if (mem_wr_ready) st <= IDLE;
        RDREQ: if (mem_rd_ready) begin cnt_q <= '0; st <= RDBEAT; end
        RDBEAT: if (mem_rdata_valid) begin
          cnt_q <= cnt_q + 1'b1;
          if (last_beat) begin
            vld[set_w][fway_q] <= 1'b1;
            plru[set_w] <= plru_next(plru[set_w], fway_q);
            if (!second_q) begin
              resp_valid <= 1'b1;
              second_q <= 1'b1;
              line_q <= line_q ^ {{(LW-1){1'b0}}, 1'b1};
              st <= PCHK;
            end else st <= IDLE;
          end
        end
        PCHK: if (hit) st <= IDLE;
              else begin fway_q <= vict; st <= RDREQ; end
        default: st <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st == LOOK && we_q && hit) dat[{set_w, hway, word_q}] <= wd_q;
    if (st == RDBEAT && mem_rdata_valid) begin
      dat[{set_w, fway_q, cnt_q}] <= mem_rdata;
      if (!second_q && cnt_q == word_q) resp_rdata <= mem_rdata;
    end
    if (last_beat) tags[set_w][fway_q] <= tag_w;
    if (st == HIT) resp_rdata <= dat[{set_w, hway_q, word_q}];
  end

  assert_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid || mem_wr_valid || mem_rdata_valid) |-> !req_ready);
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_line)));
  assert_strb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid |-> ($countones(mem_wr_strb) == 4));
  assert_wthru_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_we) |=> ##1 mem_wr_valid);
  assert_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !$past(req_valid && req_ready));
  assert_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);
  assert_onecopy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hitv));
endmodule

// File: tb/tb_sect_wt_cache.sv
module tb_sect_wt_cache;
  localparam int AW = 32;
  localparam int LW = AW - 6;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_we = 0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, resp_valid;
  logic [31:0] resp_rdata;
  logic mem_rd_valid, mem_wr_valid;
  logic mem_rdata_valid = 0;
  logic [31:0] mem_rdata = '0;
  logic [LW-1:0] mem_rd_line, mem_wr_line;
  logic [511:0] mem_wr_data;
  logic [63:0] mem_wr_strb;

  sect_wt_cache dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(1'b1), .mem_rd_line(mem_rd_line),
    .mem_rdata_valid(mem_rdata_valid), .mem_rdata(mem_rdata),
    .mem_wr_valid(mem_wr_valid), .mem_wr_ready(1'b1), .mem_wr_line(mem_wr_line),
    .mem_wr_data(mem_wr_data), .mem_wr_strb(mem_wr_strb));

  always #5 clk = ~clk;

  logic [31:0] mem [4096];
  logic [31:0] refm [4096];
  logic [31:0] exp_q [$];
  int rd_lines [$];
  int rd_count = 0, wr_count = 0, last_wr_line = -1;
  logic [63:0] last_strb = '0;
  int errors = 0, checks = 0, cycles = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // memory read responder
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && mem_rd_valid) begin
        automatic int ln = int'(mem_rd_line[7:0]);
        rd_lines.push_back(ln);
        rd_count++;
        @(negedge clk);
        for (int i = 0; i < 16; i++) begin
          mem_rdata_valid = 1;
          mem_rdata = mem[ln*16 + i];
          @(negedge clk);
        end
        mem_rdata_valid = 0;
      end
    end
  end

  // memory write responder
  always @(negedge clk) begin
    if (rst_n && mem_wr_valid) begin
      for (int w = 0; w < 16; w++)
        if (mem_wr_strb[4*w]) mem[int'(mem_wr_line[7:0])*16 + w] = mem_wr_data[32*w +: 32];
      wr_count++;
      last_wr_line = int'(mem_wr_line);
      last_strb = mem_wr_strb;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && resp_valid) begin
      if (exp_q.size() == 0) chk(0, "R3 unexpected response", resp_rdata, 0);
      else begin
        automatic logic [31:0] e = exp_q.pop_front();
        chk(resp_rdata == e, "R3 read data", resp_rdata, e);
      end
    end
  end

  task automatic send(input bit we, input int addr, input logic [31:0] wd);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_we = we; req_addr = addr; req_wdata = wd;
    if (we) refm[addr >> 2] = wd;
    else exp_q.push_back(refm[addr >> 2]);
    @(negedge clk);
    req_valid = 0;
    chk(req_ready == 0, "R8 ready low after accept", req_ready, 0);
  endtask

  task automatic wait_idle();
    while (!req_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input int addr, input int exp_reads, input string req);
    automatic int n0 = rd_count;
    send(0, addr, 0);
    wait_idle();
    chk(rd_count - n0 == exp_reads, req, rd_count - n0, exp_reads);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) begin
      mem[i] = (i * 32'h01000193) ^ 32'h5A5A0000;
      refm[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1, "R1 ready after reset", req_ready, 1);
    chk(resp_valid == 0, "R1 resp idle", resp_valid, 0);
    chk(mem_rd_valid == 0 && mem_wr_valid == 0, "R1 mem idle", {mem_rd_valid, mem_wr_valid}, 0);

    // cold miss: line 0 then partner line 1
    rd(5*4, 2, "R1 R3 R4 cold miss sector reads");
    chk(rd_lines.size() >= 2 && rd_lines[0] == 0, "R3 first burst is missing line", rd_lines[0], 0);
    chk(rd_lines.size() >= 2 && rd_lines[1] == 1, "R4 second burst is partner line", rd_lines[1], 1);

    // R2 hit timing
    begin
      automatic int n0 = rd_count;
      @(negedge clk);
      req_valid = 1; req_we = 0; req_addr = 9*4;
      exp_q.push_back(refm[9]);
      @(negedge clk); req_valid = 0;
      @(negedge clk);
      chk(resp_valid == 0, "R2 no response one edge after accept", resp_valid, 0);
      @(negedge clk);
      chk(resp_valid == 1, "R2 response two edges after accept", resp_valid, 1);
      wait_idle();
      chk(rd_count == n0, "R2 hit needs no burst", rd_count - n0, 0);
    end

    rd(64 + 8, 0, "R4 partner line hits");

    // write hit
    begin
      automatic int w0 = wr_count;
      send(1, 'h10, 32'hCAFE0001);
      wait_idle();
      chk(wr_count - w0 == 1, "R6 one write per store", wr_count - w0, 1);
      chk(last_strb == 64'hF << 16, "R6 strobe lane", last_strb, 64'hF << 16);
      chk(last_wr_line == 0, "R6 write line", last_wr_line, 0);
      rd('h10, 0, "R7 write hit updates cached copy");
    end

    // write miss, no allocate
    begin
      automatic int w0 = wr_count;
      send(1, 200*64, 32'h0BADF00D);
      wait_idle();
      chk(wr_count - w0 == 1, "R6 write-through on miss", wr_count - w0, 1);
      rd(200*64, 2, "R7 write miss not allocated");
    end

    // replacement in set 4 (partners in set 5)
    rd(4*64, 2, "R9 fill A");
    rd(36*64 + 4, 2, "R9 fill B");
    rd(68*64 + 8, 2, "R9 fill C");
    rd(100*64 + 12, 2, "R9 fill D");
    rd(4*64 + 60, 0, "R9 A hit after four fills");
    rd(132*64, 2, "R9 fill E");
    rd(4*64, 0, "R9 A kept");
    rd(36*64, 0, "R9 B kept");
    rd(100*64, 0, "R9 D kept");
    rd(132*64 + 4, 0, "R9 E kept");
    rd(68*64 + 16, 1, "R5 R9 C evicted, partner present skip");
    rd(4*64 + 4, 2, "R9 A evicted by C refill");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule